// File: doc/BRIEF.md
# Selector-Indexed Configuration Item Port

The block is a small register port from which a host pulls configuration items as byte streams. The host first writes a 16-bit selector that names one item. It then issues reads of the data register. Each read returns the next 1, 2, 4 or 8 bytes of that item. A hidden byte cursor tracks the position within the item. Writing the selector moves the cursor back to the start. A wide read places consecutive item bytes into ascending byte lanes in stream order, so no endianness swap takes place.

The items are computed at build time from parameters:
- an 8-byte signature constant at selector 0x0000;
- a 4-byte little-endian feature bitmap at selector 0x0001;
- a bank of generic table items starting at 0x0002;
- a bank of architecture-specific table items starting at 0x8000.

Selectors with bit 14 set once meant "write intent". The block now treats them as unknown items. An unknown item reads as zeros and nothing can change its contents.

The port is a two-state machine. `ST_IDLE` accepts a read, and the transition ACCEPT moves it to `ST_RESP`. In `ST_RESP` the captured data is presented for one cycle, and the transition RETIRE always returns the machine to `ST_IDLE`. The machine accepts no read while it is in `ST_RESP`.

Top module: `cfgport_top`

## Requirements
- R1: After reset, `sel_q` is 0x0000, `dat_ready` is 1 and `dat_rvalid` is 0. The cursor is zero, so the first read returns the start of the signature item.
- R2: A cycle with `sel_wr` high loads `sel_wdata` into `sel_q` on the next edge and sets the cursor to zero. A data read in the same cycle is dropped and produces no response.
- R3: `dat_size` encodes the access width: 0 means 1 byte, 1 means 2, 2 means 4 and 3 means 8. Item byte at cursor+j appears on `dat_rdata[8j+7:8j]`. Lanes at or above the access width read zero.
- R4: Each accepted read advances the cursor by the access width, but never beyond the item length. Byte positions at or past the length read as zero.
- R5: Item 0x0000 is 8 bytes long. Its stream byte k is `SIG[63-8k -: 8]`, so the most significant byte comes first.
- R6: Item 0x0001 is 4 bytes long. Byte 0 is `{6'b0, DMA_PRESENT, 1'b1}` and bytes 1 to 3 are zero, so the 32-bit value is little-endian.
- R7: Generic items sit at selectors 0x0002+i for i < NUM_GEN. Architecture items sit at 0x8000+i for i < NUM_ARCH. Both kinds are ITEM_LEN bytes long. Byte k equals `((b*64 + i*16 + k) mod 256) XOR 0x5A`, where b is 0 for the generic bank and 1 for the architecture bank.
- R8: A selector with bit 14 set, or one that names no item, reads as all zeros. Selecting it leaves the contents of every item unchanged.
- R9: A data write (`dat_wr`) produces no response and does not move the cursor.
- R10: An accepted read is one that has `dat_rd` high while `dat_ready` is high and `sel_wr` is low. It raises `dat_rvalid` for exactly one cycle on the next edge, and `dat_ready` is low during that cycle. A read presented while `dat_ready` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_wr | input | 1 | Selector write strobe |
| sel_wdata | input | 16 | New selector value |
| dat_rd | input | 1 | Data register read request |
| dat_wr | input | 1 | Data register write (ignored) |
| dat_size | input | 2 | Access width code: 0, 1, 2, 3 mean 1, 2, 4, 8 bytes |
| sel_q | output | 16 | Current selector |
| dat_ready | output | 1 | High in ST_IDLE, when a read can be accepted |
| dat_rvalid | output | 1 | Read data valid for one cycle |
| dat_rdata | output | 64 | Read data, stream byte 0 in lane 0 |

## Verification
The hardest situations to reach are the collisions at the port:
- a read that arrives in the same cycle as a selector write;
- a read held high through the `ST_RESP` cycle;
- a wide read that straddles the end of an item.

The stimulus creates each one deliberately. It pulses `sel_wr` and `dat_rd` together. It keeps `dat_rd` asserted for two cycles. It issues reads of 1, 2, 4 and 8 bytes on a 12-byte item, so that the last read is cut short. After each collision, a follow-up read shows where the cursor was left. The stimulus also leaves bit 14 set in the selector and issues data writes, then reselects a real item to confirm its bytes are unchanged.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

    typedef enum logic [2:0] {
        K_NONE,
        K_SIG,
        K_FEAT,
        K_GEN,
        K_ARCH
    } item_kind_e;

    typedef enum logic {
        ST_IDLE,
        ST_RESP
    } port_state_e;

    // Access width in bytes for a size code: 1, 2, 4 or 8.
    function automatic logic [3:0] size_bytes(input logic [1:0] code);
        return 4'd1 << code;
    endfunction

    // Byte k of an item, assuming k lies below the item length.
    function automatic logic [7:0] item_byte(
        input item_kind_e  kind,
        input logic [13:0] idx,
        input logic [7:0]  k,
        input logic [63:0] sig,
        input logic        dma
    );
        int v;
        logic [63:0] sh;
        logic [7:0] res;
        v = 0;
        sh = '0;
        res = 8'h00;
        unique case (kind)
            K_SIG: begin
                sh = sig >> (8 * (7 - int'(k[2:0])));
                res = sh[7:0];
            end
            K_FEAT: res = (k == 8'd0) ? {6'b0, dma, 1'b1} : 8'h00;
            K_GEN: begin
                v = int'(idx) * 16 + int'(k);
                res = v[7:0] ^ 8'h5A;
            end
            K_ARCH: begin
                v = 64 + int'(idx) * 16 + int'(k);
                res = v[7:0] ^ 8'h5A;
            end
            default: res = 8'h00;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/cfgport_sel_decode.sv
module cfgport_sel_decode
    import cfgport_pkg::*;
#(
    parameter int NUM_GEN  = 3,
    parameter int NUM_ARCH = 2,
    parameter int ITEM_LEN = 12,
    parameter int OFS_W    = 5
) (
    input  logic [15:0]      sel,
    output item_kind_e       kind,
    output logic [13:0]      idx,
    output logic [OFS_W-1:0] len
);

    localparam logic [13:0] GEN_END  = 14'(NUM_GEN + 2);
    localparam logic [13:0] ARCH_END = 14'(NUM_ARCH);

    always_comb begin
        kind = K_NONE;
        idx  = '0;
        len  = '0;
        // Bit 14 marks a former write-intent selector: always unknown (R8).
        if (!sel[14]) begin
            if (!sel[15]) begin
                if (sel[13:0] == 14'd0) begin
                    kind = K_SIG;
                    len  = OFS_W'(8);
                end else if (sel[13:0] == 14'd1) begin
                    kind = K_FEAT;
                    len  = OFS_W'(4);
                end else if (sel[13:0] < GEN_END) begin
                    kind = K_GEN;
                    idx  = sel[13:0] - 14'd2;
                    len  = OFS_W'(ITEM_LEN);
                end
            end else if (sel[13:0] < ARCH_END) begin
                kind = K_ARCH;
                idx  = sel[13:0];
                len  = OFS_W'(ITEM_LEN);
            end
        end
    end

endmodule

// File: rtl/cfgport_lane.sv
module cfgport_lane
    import cfgport_pkg::*;
#(
    parameter int          LANE        = 0,
    parameter int          OFS_W       = 5,
    parameter logic [63:0] SIG         = 64'h0,
    parameter logic        DMA_PRESENT = 1'b0
) (
    input  item_kind_e       kind,
    input  logic [13:0]      idx,
    input  logic [OFS_W-1:0] len,
    input  logic [OFS_W-1:0] ofs,
    input  logic [3:0]       nbytes,
    output logic [7:0]       lane_byte
);

    logic [OFS_W:0] pos;
    logic           hit;

    always_comb begin
        pos = {1'b0, ofs} + (OFS_W+1)'(LANE);
        hit = (4'(LANE) < nbytes) && (pos < {1'b0, len});
        lane_byte = hit ? item_byte(kind, idx, 8'(pos), SIG, DMA_PRESENT) : 8'h00;
    end

endmodule

// File: rtl/cfgport_top.sv
module cfgport_top
    import cfgport_pkg::*;
#(
    parameter int          NUM_GEN     = 3,
    parameter int          NUM_ARCH    = 2,
    parameter int          ITEM_LEN    = 12,
    parameter logic [63:0] SIG         = 64'h4346_4750_4F52_5431,
    parameter logic        DMA_PRESENT = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sel_wr,
    input  logic [15:0] sel_wdata,
    input  logic        dat_rd,
    input  logic        dat_wr,
    input  logic [1:0]  dat_size,
    output logic [15:0] sel_q,
    output logic        dat_ready,
    output logic        dat_rvalid,
    output logic [63:0] dat_rdata
);

    localparam int MAX_LEN = (ITEM_LEN > 8) ? ITEM_LEN : 8;
    localparam int OFS_W   = $clog2(MAX_LEN + 1);
    localparam int LANES   = 8;

    port_state_e      state, state_nx;
    item_kind_e       kind;
    logic [13:0]      idx;
    logic [OFS_W-1:0] len;
    logic [OFS_W-1:0] ofs, ofs_nx;
    logic [OFS_W:0]   ofs_sum;
    logic [3:0]       nbytes;
    logic             rd_accept;
    logic [63:0]      lanes, rdata_q;

    // Data writes (dat_wr) reach no logic: they are ignored (R9).

    cfgport_sel_decode #(
        .NUM_GEN (NUM_GEN),
        .NUM_ARCH(NUM_ARCH),
        .ITEM_LEN(ITEM_LEN),
        .OFS_W   (OFS_W)
    ) dec_i (
        .sel (sel_q),
        .kind(kind),
        .idx (idx),
        .len (len)
    );

    assign nbytes = size_bytes(dat_size);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        cfgport_lane #(
            .LANE       (g),
            .OFS_W      (OFS_W),
            .SIG        (SIG),
            .DMA_PRESENT(DMA_PRESENT)
        ) lane_i (
            .kind     (kind),
            .idx      (idx),
            .len      (len),
            .ofs      (ofs),
            .nbytes   (nbytes),
            .lane_byte(lanes[8*g +: 8])
        );
    end

    // Saturating cursor advance (R4).
    always_comb begin
        ofs_sum = {1'b0, ofs} + (OFS_W+1)'(nbytes);
        ofs_nx  = (ofs_sum > {1'b0, len}) ? len : ofs_sum[OFS_W-1:0];
    end

    assign rd_accept = (state == ST_IDLE) && dat_rd && !sel_wr;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions: ACCEPT (ST_IDLE -> ST_RESP), RETIRE (ST_RESP -> ST_IDLE).
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (rd_accept) state_nx = ST_RESP;
            ST_RESP: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // Selector, cursor and captured read data.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q   <= 16'h0000;
            ofs     <= '0;
            rdata_q <= '0;
        end else if (sel_wr) begin
            sel_q <= sel_wdata;
            ofs   <= '0;
        end else if (rd_accept) begin
            ofs     <= ofs_nx;
            rdata_q <= lanes;
        end
    end

    // Outputs.
    always_comb begin
        dat_ready  = (state == ST_IDLE);
        dat_rvalid = (state == ST_RESP);
        dat_rdata  = rdata_q;
    end

endmodule

// File: rtl/cfgport_chk.sv
module cfgport_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        sel_wr,
    input logic [15:0] sel_wdata,
    input logic        dat_rd,
    input logic        dat_wr,
    input logic [1:0]  dat_size,
    input logic [15:0] sel_q,
    input logic        dat_ready,
    input logic        dat_rvalid,
    input logic [63:0] dat_rdata
);

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (sel_q == 16'h0000 && !dat_rvalid));

    p_sel_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sel_wr |=> (sel_q == $past(sel_wdata)));

    p_sel_drops_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_wr && dat_rd) |=> !dat_rvalid);

    p_upper_lanes_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dat_rvalid |-> ((dat_rdata >> (7'd8 << $past(dat_size))) == 64'd0));

    p_unknown_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_rvalid && $past(sel_q[14])) |-> (dat_rdata == 64'd0));

    p_write_no_resp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_ready && dat_wr && !dat_rd) |=> !dat_rvalid);

    p_resp_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_ready && dat_rd && !sel_wr) |=> (dat_rvalid && !dat_ready));

    p_single_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dat_rvalid |=> !dat_rvalid);

endmodule

bind cfgport_top cfgport_chk chk_i (.*);

// File: tb/cfgport_top_tb_top.sv
`timescale 1ns/1ps
module cfgport_top_tb_top;

    localparam logic [63:0] SIG = 64'h4346_4750_4F52_5431;
    localparam int ITEM_LEN = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_wr = 1'b0;
    logic [15:0] sel_wdata = 16'h0;
    logic        dat_rd = 1'b0;
    logic        dat_wr = 1'b0;
    logic [1:0]  dat_size = 2'd0;
    logic [15:0] sel_q;
    logic        dat_ready;
    logic        dat_rvalid;
    logic [63:0] dat_rdata;

    int tests = 0;
    int fails = 0;
    int resp_seen = 0;
    int resp_exp = 0;

    logic [63:0] exp_q[$];
    string       tag_q[$];

    int          m_ofs = 0;
    logic [15:0] m_sel = 16'h0;

    always #2.5 clk = ~clk;

    cfgport_top dut_i (
        .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_wdata(sel_wdata),
        .dat_rd(dat_rd), .dat_wr(dat_wr), .dat_size(dat_size),
        .sel_q(sel_q), .dat_ready(dat_ready), .dat_rvalid(dat_rvalid),
        .dat_rdata(dat_rdata)
    );

    function automatic int ref_len(input logic [15:0] s);
        if (s == 16'h0000) return 8;
        if (s == 16'h0001) return 4;
        if (s >= 16'h0002 && s <= 16'h0004) return ITEM_LEN;
        if (s >= 16'h8000 && s <= 16'h8001) return ITEM_LEN;
        return 0;
    endfunction

    function automatic logic [7:0] ref_byte(input logic [15:0] s, input int k);
        int v;
        if (k >= ref_len(s)) return 8'h00;
        if (s == 16'h0000) return SIG[(7-k)*8 +: 8];
        if (s == 16'h0001) return (k == 0) ? 8'h01 : 8'h00;
        if (s <= 16'h0004) begin
            v = (int'(s) - 2) * 16 + k;
            return v[7:0] ^ 8'h5A;
        end
        v = 64 + (int'(s) - 32768) * 16 + k;
        return v[7:0] ^ 8'h5A;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard whenever a response appears.
    always @(negedge clk) begin
        if (rst_n && dat_rvalid) begin
            resp_seen++;
            if (exp_q.size() == 0) begin
                tests++;
                fails++;
                $display("FAIL R10: unexpected response actual %h expected none", dat_rdata);
            end else begin
                check(tag_q.pop_front(), dat_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic sel_write(input logic [15:0] v);
        sel_wr = 1'b1; sel_wdata = v;
        @(negedge clk);
        sel_wr = 1'b0;
        m_sel = v; m_ofs = 0;
    endtask

    task automatic push_read(input logic [1:0] sz, input string tag);
        int n;
        int l;
        logic [63:0] e;
        n = 1 << sz;
        l = ref_len(m_sel);
        e = '0;
        for (int j = 0; j < n; j++) e[8*j +: 8] = ref_byte(m_sel, m_ofs + j);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        resp_exp++;
        m_ofs = (m_ofs + n > l) ? l : m_ofs + n;
    endtask

    task automatic do_read(input logic [1:0] sz, input string tag);
        push_read(sz, tag);
        dat_rd = 1'b1; dat_size = sz;
        @(negedge clk);
        dat_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_read_held(input logic [1:0] sz, input string tag);
        push_read(sz, tag);
        dat_rd = 1'b1; dat_size = sz;
        @(negedge clk);
        @(negedge clk);
        dat_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_write(input logic [1:0] sz);
        dat_wr = 1'b1; dat_size = sz;
        @(negedge clk);
        dat_wr = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 200000);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 sel_q", 64'(sel_q), 64'h0);
        check("R1 ready", 64'(dat_ready), 64'h1);
        check("R1 rvalid", 64'(dat_rvalid), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        do_read(2'd3, "R1 R5 signature after reset");
        do_read(2'd3, "R4 past end of signature");

        sel_write(16'h0001);
        do_read(2'd2, "R6 feature bitmap");
        do_read(2'd0, "R4 feature past end");

        sel_write(16'h0002);
        do_read(2'd0, "R3 one byte");
        do_read(2'd1, "R3 two bytes");
        do_read(2'd2, "R3 four bytes");
        do_read(2'd3, "R3 R4 eight bytes straddling end");

        sel_write(16'h8001);
        do_read(2'd3, "R7 arch item head");
        do_read(2'd3, "R7 R4 arch item tail");
        sel_write(16'h0004);
        do_read(2'd3, "R7 last generic item");

        sel_write(16'h0005);
        do_read(2'd3, "R8 unknown generic selector");
        sel_write(16'h8002);
        do_read(2'd3, "R8 unknown arch selector");
        sel_write(16'h4002);
        do_write(2'd3);
        do_write(2'd0);
        do_read(2'd3, "R8 write-intent selector reads zero");
        sel_write(16'hC000);
        do_read(2'd2, "R8 arch write-intent selector reads zero");
        sel_write(16'h0002);
        do_read(2'd3, "R8 item unchanged after write-intent select");

        sel_write(16'h0003);
        do_read(2'd1, "R9 before write");
        do_write(2'd1);
        do_read(2'd1, "R9 cursor kept after write");

        // Selector write and read in the same cycle: read dropped.
        sel_wr = 1'b1; sel_wdata = 16'h0002; dat_rd = 1'b1; dat_size = 2'd3;
        @(negedge clk);
        sel_wr = 1'b0; dat_rd = 1'b0;
        m_sel = 16'h0002; m_ofs = 0;
        @(negedge clk);
        check("R2 sel_q loaded", 64'(sel_q), 64'h0002);
        do_read(2'd2, "R2 cursor at zero after collision");
        sel_write(16'h0002);
        do_read(2'd2, "R2 reselect restarts cursor");

        do_read_held(2'd1, "R10 held read counted once");
        do_read(2'd1, "R10 continuation after held read");

        repeat (3) @(negedge clk);
        check("R10 response count", 64'(resp_seen), 64'(resp_exp));
        check("R10 scoreboard drained", 64'(exp_q.size()), 64'h0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule